// File: doc/BRIEF.md
# Machine Control and Status Register Bank

This block is the control and status register bank of a small 64-bit core. The pipeline presents a 12-bit register address with separate read and write strobes and 64-bit write data. The bank returns 64-bit read data combinationally from the address. A write takes effect at the next rising clock edge.

The bank holds one 8-bit floating-point control word. Three addresses reach it: the whole word, its exception-flag field alone and its rounding-mode field alone. It also keeps four full-width machine trap registers (scratch, trap vector, exception PC and cause), a fixed ISA descriptor, and zero-reading identity registers. Three counters run inside the bank: clock cycles, retired instructions and a tick-driven time base. Each counter can be read whole or as its upper 32 bits. The cycle and retire counters can also be loaded through machine-level alias addresses. Any address whose two top bits are both set is read-only, and writes to it are dropped. A read of an address the bank does not implement returns zero and flags an illegal access.

Top module: `csr_bank`

## Requirements
- R1: After reset the floating-point word, the trap registers and all counters read zero. Address 0x301 reads 64'h8000000000101129. Addresses 0xF11, 0xF12, 0xF13 and 0xF14 read zero.
- R2: Address 0x001 reads the floating-point word bits 4:0, zero-extended. A write there replaces only bits 4:0, with wdata[4:0].
- R3: Address 0x002 reads the floating-point word bits 7:5, zero-extended. A write there replaces only bits 7:5, with wdata[2:0], and leaves the flags unchanged.
- R4: A write to address 0x003 stores wdata[7:0] as the whole word. A read of 0x003 returns that word zero-extended to 64 bits.
- R5: A write to any address with addr[11:10] == 2'b11 changes no state.
- R6: Addresses 0x340 (scratch), 0x305 (trap vector), 0x341 (exception PC) and 0x342 (cause) hold full 64-bit values. Each reads back what was last written to it.
- R7: The cycle counter increases by one on every clock edge. It is read whole at 0xC00 and 0xB00, and its bits 63:32 are read at 0xC80.
- R8: The retire counter increases by one on each edge where retire is high. It is read whole at 0xC02 and 0xB02, and its bits 63:32 are read at 0xC82.
- R9: The time counter increases by one on each edge where tick is high. It is read whole at 0xC01, and its bits 63:32 are read at 0xC81.
- R10: A write to 0xB00 or 0xB02 loads the cycle or retire counter. If an increment falls in the same cycle, the written value wins and no increment is added.
- R11: A read strobe on an unimplemented address returns zero on rdata. The illegal output is then high for exactly the one cycle after that edge.
- R12: Writes to address 0x301 are ignored, and it keeps its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 64 | Write data |
| retire | input | 1 | One instruction retired this cycle |
| tick | input | 1 | Time-base advance enable |
| rdata | output | 64 | Read data, combinational from addr |
| illegal | output | 1 | Unimplemented address was read on the previous edge |

## Verification
Two functions can act on a counter in the same cycle: a software load through the 0xB00 or 0xB02 alias, and the counter's own increment. The bench provokes this by writing the retire counter while retire is held high, and by writing the cycle counter, which advances on every edge. It then reads the counter in the very next cycle and expects exactly the written value. A second collision is a simultaneous read and dropped write at 0xC00; here the read must show the normal increment and no trace of the write data.

// File: rtl/csr_bank.sv
module csr_bank #(
  parameter int          XW       = 64,
  parameter int          AW       = 12,
  parameter int          FPW      = 8,
  parameter logic [63:0] ISA_INIT = 64'h8000000000101129
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [XW-1:0] wdata,
  input  logic          retire,
  input  logic          tick,
  output logic [XW-1:0] rdata,
  output logic          illegal
);
  localparam int HW = XW / 2;

  logic [FPW-1:0] fp_ctl;
  logic [XW-1:0]  m_scratch, m_tvec, m_epc, m_cause;
  logic [XW-1:0]  cyc_cnt, ret_cnt, tim_cnt;
  logic           hit;

  wire wr_ok  = wr_en && (addr[AW-1:AW-2] != 2'b11);
  wire ld_cyc = wr_ok && addr == 12'hB00;
  wire ld_ret = wr_ok && addr == 12'hB02;

  always_comb begin
    hit   = 1'b1;
    rdata = '0;
    case (addr)
      12'h001: rdata = XW'(fp_ctl[4:0]);
      12'h002: rdata = XW'(fp_ctl[7:5]);
      12'h003: rdata = XW'(fp_ctl);
      12'h301: rdata = ISA_INIT;
      12'h305: rdata = m_tvec;
      12'h340: rdata = m_scratch;
      12'h341: rdata = m_epc;
      12'h342: rdata = m_cause;
      12'hB00, 12'hC00: rdata = cyc_cnt;
      12'hB02, 12'hC02: rdata = ret_cnt;
      12'hC01: rdata = tim_cnt;
      12'hC80: rdata = cyc_cnt >> HW;
      12'hC81: rdata = tim_cnt >> HW;
      12'hC82: rdata = ret_cnt >> HW;
      12'hF11, 12'hF12, 12'hF13, 12'hF14: rdata = '0;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_ctl    <= '0;
      m_scratch <= '0;
      m_tvec    <= '0;
      m_epc     <= '0;
      m_cause   <= '0;
    end else if (wr_ok) begin
      case (addr)
        12'h001: fp_ctl[4:0] <= wdata[4:0];
        12'h002: fp_ctl[7:5] <= wdata[2:0];
        12'h003: fp_ctl      <= wdata[FPW-1:0];
        12'h305: m_tvec      <= wdata;
        12'h340: m_scratch   <= wdata;
        12'h341: m_epc       <= wdata;
        12'h342: m_cause     <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
      ret_cnt <= '0;
      tim_cnt <= '0;
      illegal <= 1'b0;
    end else begin
      cyc_cnt <= ld_cyc ? wdata : cyc_cnt + 1'b1;
      if (ld_ret)      ret_cnt <= wdata;
      else if (retire) ret_cnt <= ret_cnt + 1'b1;
      if (tick)        tim_cnt <= tim_cnt + 1'b1;
      illegal <= rd_en && !hit;
    end
  end
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic        retire,
  input logic        tick,
  input logic        illegal,
  input logic [7:0]  fp,
  input logic [63:0] scr,
  input logic [63:0] cyc,
  input logic [63:0] ret,
  input logic [63:0] tim
);
  AST_RO_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[11:10] == 2'b11) |=> ($stable(fp) && $stable(scr))); // R5
  AST_FLAGS_KEEP_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h001) |=> (fp[7:5] == $past(fp[7:5]))); // R2
  AST_ROUND_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h002) |=> (fp[4:0] == $past(fp[4:0]))); // R3
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 12'hB00) |=> (cyc == $past(cyc) + 64'd1)); // R7
  AST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire && !(wr_en && addr == 12'hB02)) |=> $stable(ret)); // R8
  AST_TIME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tim)); // R9
  AST_ILLEGAL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(rd_en)); // R11
endmodule

bind csr_bank csr_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .retire(retire), .tick(tick), .illegal(illegal), .fp(fp_ctl),
  .scr(m_scratch), .cyc(cyc_cnt), .ret(ret_cnt), .tim(tim_cnt)
);

// File: tb/sim_csr_bank.sv
`timescale 1ns/1ps
module sim_csr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, retire = 1'b0, tick = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        illegal;
  int          runs = 0, fails = 0;
  logic [63:0] v;

  always #2.5 clk = ~clk;

  csr_bank u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
               .wdata(wdata), .retire(retire), .tick(tick), .rdata(rdata), .illegal(illegal));

  localparam int NV = 19;
  localparam logic [140:0] VEC [NV] = '{
    {1'b0, 12'h003, 64'hFFFF_FFFF_FFFF_FFA5, 64'h0},
    {1'b1, 12'h003, 64'h0, 64'hA5},
    {1'b1, 12'h001, 64'h0, 64'h05},
    {1'b1, 12'h002, 64'h0, 64'h05},
    {1'b0, 12'h001, 64'hFFFF_FFFF_FFFF_FFFA, 64'h0},
    {1'b1, 12'h003, 64'h0, 64'hBA},
    {1'b1, 12'h002, 64'h0, 64'h05},
    {1'b0, 12'h002, 64'hFFFF_FFFF_FFFF_FFF3, 64'h0},
    {1'b1, 12'h003, 64'h0, 64'h7A},
    {1'b1, 12'h001, 64'h0, 64'h1A},
    {1'b0, 12'h340, 64'h0123_4567_89AB_CDEF, 64'h0},
    {1'b1, 12'h340, 64'h0, 64'h0123_4567_89AB_CDEF},
    {1'b0, 12'h305, 64'hFEDC_BA98_7654_3210, 64'h0},
    {1'b1, 12'h305, 64'h0, 64'hFEDC_BA98_7654_3210},
    {1'b0, 12'h341, 64'h0000_0000_0000_1000, 64'h0},
    {1'b0, 12'h342, 64'h8000_0000_0000_0007, 64'h0},
    {1'b1, 12'h341, 64'h0, 64'h0000_0000_0000_1000},
    {1'b1, 12'h342, 64'h0, 64'h8000_0000_0000_0007},
    {1'b1, 12'h340, 64'h0, 64'h0123_4567_89AB_CDEF}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    rd_en = 1'b0; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [63:0] exp);
    @(negedge clk);
    wr_en = 1'b0; addr = a; rd_en = 1'b1;
    #1 chk(req, rdata, exp);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 fp word", 12'h003, 64'h0);
    rd("R1 scratch", 12'h340, 64'h0);
    rd("R1 isa", 12'h301, 64'h8000000000101129);
    rd("R1 id F11", 12'hF11, 64'h0);
    rd("R1 id F14", 12'hF14, 64'h0);
    rd("R1 time", 12'hC01, 64'h0);
    rd("R1 retire", 12'hC02, 64'h0);
    chk("R11 no illegal on legal reads", {63'h0, illegal}, 64'h0);

    // R2 R3 R4 R6 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][140] == 1'b0) wr(VEC[i][139:128], VEC[i][127:64]);
      else rd("R2/R3/R4/R6 vector", VEC[i][139:128], VEC[i][63:0]);
    end

    // R12 isa ignores writes
    wr(12'h301, 64'h0);
    rd("R12 isa unchanged", 12'h301, 64'h8000000000101129);

    // R5 dropped write alongside a read of the cycle counter
    @(negedge clk);
    addr = 12'hC00; rd_en = 1'b1;
    #1 v = rdata;
    wdata = 64'hDEAD_BEEF_0000_0000; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R5 cycle unaffected by write", rdata, v + 64'd1);
    wr(12'hF14, 64'h1234);
    rd("R5 hart id still zero", 12'hF14, 64'h0);
    wr(12'hC03, 64'hFF);
    rd("R5 fp word intact", 12'h003, 64'h7A);

    // R7 R10 cycle load wins, then upper half
    @(negedge clk);
    rd_en = 1'b0; addr = 12'hB00; wdata = 64'h0000_0007_FFFF_FFFF; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1;
    #1 chk("R10 cycle load wins", rdata, 64'h0000_0007_FFFF_FFFF);
    @(negedge clk);
    #1 chk("R7 cycle step", rdata, 64'h0000_0008_0000_0000);
    addr = 12'hC80;
    #1 chk("R7 cycle upper half", rdata, 64'h8);

    // R8 R10 retire load with retire high
    @(negedge clk);
    rd_en = 1'b0; addr = 12'hB02; wdata = 64'h0000_0001_FFFF_FFFE; wr_en = 1'b1; retire = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1;
    #1 chk("R10 retire load wins", rdata, 64'h0000_0001_FFFF_FFFE);
    repeat (3) @(negedge clk);
    retire = 1'b0;
    addr = 12'hC02;
    #1 chk("R8 retire counts", rdata, 64'h0000_0002_0000_0001);
    @(negedge clk);
    #1 chk("R8 retire holds", rdata, 64'h0000_0002_0000_0001);
    addr = 12'hC82;
    #1 chk("R8 retire upper half", rdata, 64'h2);

    // R9 time base
    @(negedge clk);
    tick = 1'b1;
    repeat (2) @(negedge clk);
    tick = 1'b0;
    addr = 12'hC01;
    #1 chk("R9 time ticks", rdata, 64'h2);
    @(negedge clk);
    #1 chk("R9 time holds", rdata, 64'h2);
    addr = 12'hC81;
    #1 chk("R9 time upper half", rdata, 64'h0);

    // R11 unimplemented read
    @(negedge clk);
    addr = 12'h7C0; rd_en = 1'b1;
    #1 chk("R11 zero data", rdata, 64'h0);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 illegal raised", {63'h0, illegal}, 64'h1);
    @(negedge clk);
    chk("R11 illegal one cycle", {63'h0, illegal}, 64'h0);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule